// File: doc/BRIEF.md
# BCD Watchdog Timer with Reset/Interrupt Steering

This block is a watchdog timer whose timeout is programmed as two binary-coded-decimal bytes: one byte of whole seconds and one byte of hundredths. The longest timeout is 99.99 seconds. A down-counter of four BCD digits steps once per pulse on a 100 Hz tick input. Each time it runs out, the block sets a status flag, reloads itself from the programmed period and raises one of two outputs. A steering bit in the control register chooses the output: an interrupt level that the host clears, or a reset pulse of fixed length.

The host works through a small byte-wide register port. It programs the period and sets the enable and steering bits. It services the watchdog by writing either period byte again, which restarts the count from the full period. A period of 00.00 keeps the watchdog idle. The 100 Hz tick comes from outside the block.

Top module: `bcd_wdt`

## Requirements
- R1: After reset both outputs are low, and reads of offsets 0xC, 0xD, 0xE and 0xF all return 0x00.
- R2: The hundredths byte is at offset 0xC and the seconds byte at offset 0xD. Both read back as written. Offset 0xE is read-only, so writing to it leaves its read value unchanged.
- R3: With enable set, the watchdog expires after exactly sec*100+hund ticks. The count steps down in BCD across digit borrows, and this holds up to 99.99, which is 9999 ticks.
- R4: Any write to offset 0xC or 0xD reloads the count with the full period, including the new byte. A write in the same cycle as a tick takes precedence over that tick.
- R5: While both period bytes are 00, no tick ever causes an expiry.
- R6: Expiry sets the flag at bit 1 of offset 0xE. A read of 0xE returns the flag and then clears it. If an expiry happens in the same cycle as that read, the flag stays set.
- R7: When bit 0 of offset 0xF (steering) is 0, `wdt_irq_o` is high exactly while the flag is set and the enable bit is 1.
- R8: When steering is 1, each expiry drives `wdt_rst_o` high for exactly 16 clock cycles. An expiry during a pulse does not extend it, and `wdt_irq_o` stays low.
- R9: While bit 1 of offset 0xF (enable) is 0, ticks are ignored and the count holds its value. When the bit returns to 1, counting resumes from where it stopped.
- R10: After an expiry the count reloads on its own, so the next expiry follows one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz tick, one cycle wide |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe (a read of 0xE clears the flag) |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| wdt_rst_o | output | 1 | Reset pulse on expiry when steering is 1 |
| wdt_irq_o | output | 1 | Interrupt level on expiry when steering is 0 |

## Verification
The down-counter is not readable, so a wrong digit or a borrow error appears only as an expiry on the wrong tick. The bench therefore checks that the outputs stay low on tick P-1 and rise exactly on tick P. It does this for random short periods, for a period of one tick, for a period that borrows across the seconds boundary, and for 99.99. A missed reload or a wrong hold shows up one full period later, as an expiry that is early or late. A flag or pulse-length fault is visible on the very next read of offset 0xE or within 16 cycles of the expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int DIG_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_HUND = 4'hC;
  localparam logic [ADDR_W-1:0] OFS_SEC  = 4'hD;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'hE;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'hF;

  localparam int CTRL_EN_BIT    = 1;
  localparam int CTRL_STEER_BIT = 0;
  localparam int STAT_FLAG_BIT  = 1;
endpackage

// File: rtl/wdt_bcd_cnt.sv
module wdt_bcd_cnt
  import wdt_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int W = NDIG * DIG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o,
  output logic         zero_o
);
  logic [NDIG-1:0][DIG_W-1:0] dig_q, dig_dec;
  logic [NDIG:0]              borrow;

  assign borrow[0] = 1'b1;

  // ripple-borrow BCD decrement, one stage per digit
  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    always_comb begin
      if (!borrow[i]) begin
        dig_dec[i]    = dig_q[i];
        borrow[i+1]   = 1'b0;
      end else if (dig_q[i] == '0) begin
        dig_dec[i]    = DIG_W'(9);
        borrow[i+1]   = 1'b1;
      end else begin
        dig_dec[i]    = dig_q[i] - DIG_W'(1);
        borrow[i+1]   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dig_q <= '0;
    else if (load_i) dig_q <= load_val_i;
    else if (dec_i)  dig_q <= dig_dec;
  end

  assign cnt_o  = dig_q;
  assign zero_o = (dig_q == '0);
  assign last_o = (dig_q == W'(1));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  localparam int PER_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PER_W-1:0]  period_next_o,
  output logic              period_wr_o,
  output logic              stat_rd_o,
  output logic              en_o,
  output logic              steer_o,
  output logic              flag_o
);
  logic [DATA_W-1:0] hund_q, sec_q, hund_d, sec_d;
  logic              en_q, steer_q, flag_q;
  logic              wr_hund, wr_sec, wr_ctrl;

  assign wr_hund     = we_i && (addr_i == OFS_HUND);
  assign wr_sec      = we_i && (addr_i == OFS_SEC);
  assign wr_ctrl     = we_i && (addr_i == OFS_CTRL);
  assign stat_rd_o   = re_i && (addr_i == OFS_STAT);
  assign period_wr_o = wr_hund || wr_sec;

  assign hund_d = wr_hund ? wdata_i : hund_q;
  assign sec_d  = wr_sec  ? wdata_i : sec_q;
  assign period_next_o = {sec_d, hund_d};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hund_q  <= '0;
      sec_q   <= '0;
      en_q    <= 1'b0;
      steer_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      hund_q <= hund_d;
      sec_q  <= sec_d;
      if (wr_ctrl) begin
        en_q    <= wdata_i[CTRL_EN_BIT];
        steer_q <= wdata_i[CTRL_STEER_BIT];
      end
      // set beats read-clear
      if (expire_i)       flag_q <= 1'b1;
      else if (stat_rd_o) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_HUND: rdata_o = hund_q;
      OFS_SEC:  rdata_o = sec_q;
      OFS_STAT: rdata_o[STAT_FLAG_BIT] = flag_q;
      OFS_CTRL: begin
        rdata_o[CTRL_EN_BIT]    = en_q;
        rdata_o[CTRL_STEER_BIT] = steer_q;
      end
      default:  rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign steer_o = steer_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 16,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (cnt_q != '0)          cnt_q <= cnt_q - CW'(1);
    else if (fire_i)               cnt_q <= CW'(LEN);
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/bcd_wdt.sv
module bcd_wdt
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              wdt_rst_o,
  output logic              wdt_irq_o
);
  localparam int PER_W = 2 * DATA_W;
  localparam int NDIG  = PER_W / DIG_W;

  logic [PER_W-1:0] period_next, count;
  logic period_wr, stat_rd, en_q, steer_q, flag_q;
  logic last, zero, expire, step, load;

  wdt_regs u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .we_i          (reg_we_i),
    .re_i          (reg_re_i),
    .expire_i      (expire),
    .rdata_o       (reg_rdata_o),
    .period_next_o (period_next),
    .period_wr_o   (period_wr),
    .stat_rd_o     (stat_rd),
    .en_o          (en_q),
    .steer_o       (steer_q),
    .flag_o        (flag_q)
  );

  assign step   = tick_i && en_q && !zero && !period_wr;
  assign expire = step && last;
  assign load   = period_wr || expire;

  wdt_bcd_cnt #(.NDIG(NDIG)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (period_next),
    .dec_i      (step && !last),
    .cnt_o      (count),
    .last_o     (last),
    .zero_o     (zero)
  );

  wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (expire && steer_q),
    .pulse_o (wdt_rst_o)
  );

  assign wdt_irq_o = flag_q && en_q && !steer_q;
endmodule

// File: rtl/bcd_wdt_chk.sv
module bcd_wdt_chk #(
  parameter int PULSE_LEN = 16,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wdt_rst_o,
  input logic          wdt_irq_o,
  input logic          en_q,
  input logic          steer_q,
  input logic          flag_q,
  input logic          period_wr,
  input logic          stat_rd,
  input logic          expire,
  input logic          zero,
  input logic [CW-1:0] count
);
  logic [7:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= '0;
    else if (wdt_rst_o) run_q <= run_q + 8'd1;
    else                run_q <= '0;
  end

  assert_pulse_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_rst_o) |-> run_q == 8'(PULSE_LEN));
  assert_pulse_steered_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> $past(steer_q));
  assert_irq_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_irq_o |-> (en_q && !steer_q && flag_q));
  assert_hold_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !period_wr) |=> $stable(count));
  assert_zero_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero && !period_wr) |=> zero);
  assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> flag_q);
  assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !expire) |=> !flag_q);
endmodule

bind bcd_wdt bcd_wdt_chk #(.PULSE_LEN(PULSE_LEN), .CW(PER_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wdt_rst_o (wdt_rst_o),
  .wdt_irq_o (wdt_irq_o),
  .en_q      (en_q),
  .steer_q   (steer_q),
  .flag_q    (flag_q),
  .period_wr (period_wr),
  .stat_rd   (stat_rd),
  .expire    (expire),
  .zero      (zero),
  .count     (count)
);

// File: tb/bcd_wdt_tb.sv
module bcd_wdt_tb;
  logic       clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic       reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [7:0] reg_rdata_o;
  logic       wdt_rst_o, wdt_irq_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  bcd_wdt u_dut (.*);

  always #4 clk_i = ~clk_i;

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int ticks_of(input logic [7:0] s, input logic [7:0] h);
    return (s[7:4] * 10 + s[3:0]) * 100 + h[7:4] * 10 + h[3:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i); reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask
  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i); reg_addr_i = a; reg_re_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk_i); reg_re_i = 1'b0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask
  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
    end
  end

  logic [7:0] d;
  int plen, p;
  logic [7:0] h, s;
  bit st;

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(!wdt_rst_o && !wdt_irq_o, "R1 outputs", {wdt_rst_o, wdt_irq_o}, 0);
    for (int a = 12; a < 16; a++) begin
      rd(4'(a), d);
      chk(d == 0, "R1 regs", d, 0);
    end

    // R2 readback, status read-only
    wr(4'hC, 8'h37); wr(4'hD, 8'h42);
    rd(4'hC, d); chk(d == 8'h37, "R2 hund", d, 8'h37);
    rd(4'hD, d); chk(d == 8'h42, "R2 sec", d, 8'h42);
    wr(4'hE, 8'hFF);
    rd(4'hE, d); chk(d == 8'h00, "R2 stat ro", d, 0);

    // R5 zero period never expires
    wr(4'hC, 8'h00); wr(4'hD, 8'h00); wr(4'hF, 8'h02);
    ticks(30);
    chk(!wdt_irq_o, "R5 irq", wdt_irq_o, 0);
    rd(4'hE, d); chk(d == 0, "R5 flag", d, 0);

    // R3 one-tick period, R7 irq mode, R6 read clears
    wr(4'hC, 8'h01);
    ticks(1);
    chk(wdt_irq_o, "R3 P=1", wdt_irq_o, 1);
    rd(4'hE, d); chk(d == 8'h02, "R6 flag read", d, 2);
    chk(!wdt_irq_o, "R6 cleared", wdt_irq_o, 0);

    // R4 reload on write, R10 auto reload
    wr(4'hC, 8'h05);
    ticks(3);
    wr(4'hC, 8'h05);
    ticks(4);
    chk(!wdt_irq_o, "R4 reload early", wdt_irq_o, 0);
    ticks(1);
    chk(wdt_irq_o, "R4 reload expiry", wdt_irq_o, 1);
    rd(4'hE, d);
    ticks(4);
    chk(!wdt_irq_o, "R10 early", wdt_irq_o, 0);
    ticks(1);
    chk(wdt_irq_o, "R10 expiry", wdt_irq_o, 1);
    // R6 read collides with expiry: set wins
    rd(4'hE, d);
    ticks(4);
    @(negedge clk_i); reg_addr_i = 4'hE; reg_re_i = 1'b1; tick_i = 1'b1;
    @(negedge clk_i); reg_re_i = 1'b0; tick_i = 1'b0;
    chk(wdt_irq_o, "R6 set wins", wdt_irq_o, 1);
    rd(4'hE, d); chk(d == 8'h02, "R6 set wins flag", d, 2);

    // R9 hold while disabled
    wr(4'hC, 8'h05);
    ticks(2);
    wr(4'hF, 8'h00);
    ticks(10);
    chk(!wdt_irq_o, "R9 disabled", wdt_irq_o, 0);
    rd(4'hE, d); chk(d == 0, "R9 no flag", d, 0);
    wr(4'hF, 8'h02);
    ticks(2);
    chk(!wdt_irq_o, "R9 resume early", wdt_irq_o, 0);
    ticks(1);
    chk(wdt_irq_o, "R9 resume expiry", wdt_irq_o, 1);
    rd(4'hE, d);

    // R8 reset steering, 16-cycle pulse
    wr(4'hF, 8'h03); wr(4'hC, 8'h03);
    ticks(3);
    plen = 0;
    while (wdt_rst_o && plen < 100) begin
      chk(!wdt_irq_o, "R8 irq low", wdt_irq_o, 0);
      plen++; @(negedge clk_i);
    end
    chk(plen == 16, "R8 pulse len", plen, 16);
    rd(4'hE, d); chk(d == 8'h02, "R8 flag", d, 2);

    // R8 no extension: 1-tick period, ticks every 2 cycles during pulse
    wr(4'hC, 8'h01);
    ticks(1);
    plen = 0;
    fork
      ticks(6);
      begin
        while (wdt_rst_o && plen < 100) begin plen++; @(negedge clk_i); end
      end
    join
    chk(plen == 16, "R8 no extend", plen, 16);
    repeat (20) @(negedge clk_i);
    rd(4'hE, d);

    // R3 borrow across seconds (1.00) and max 99.99
    wr(4'hF, 8'h02);
    wr(4'hC, 8'h00); wr(4'hD, 8'h01);
    ticks(99);
    chk(!wdt_irq_o, "R3 1.00 early", wdt_irq_o, 0);
    ticks(1);
    chk(wdt_irq_o, "R3 1.00 expiry", wdt_irq_o, 1);
    rd(4'hE, d);
    wr(4'hC, 8'h99); wr(4'hD, 8'h99);
    ticks(9998);
    chk(!wdt_irq_o, "R3 99.99 early", wdt_irq_o, 0);
    ticks(1);
    chk(wdt_irq_o, "R3 99.99 expiry", wdt_irq_o, 1);
    rd(4'hE, d);

    // random short periods with random steering
    for (int k = 0; k < 8; k++) begin
      h  = to_bcd(1 + int'($urandom % 40));
      s  = 8'h00;
      st = 1'($urandom);
      p  = ticks_of(s, h);
      wr(4'hF, {6'b0, 1'b1, st});
      wr(4'hD, s); wr(4'hC, h);
      ticks(p - 1);
      chk(!wdt_irq_o && !wdt_rst_o, "R3 rand early", {wdt_rst_o, wdt_irq_o}, 0);
      ticks(1);
      if (st) chk(wdt_rst_o && !wdt_irq_o, "R8 rand", {wdt_rst_o, wdt_irq_o}, 2);
      else    chk(wdt_irq_o && !wdt_rst_o, "R7 rand", {wdt_rst_o, wdt_irq_o}, 1);
      repeat (20) @(negedge clk_i);
      rd(4'hE, d); chk(d == 8'h02, "R6 rand flag", d, 2);
    end

    summary();
  end
endmodule